// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits beside a processor core and picks the low-power depth to enter when the core retires a sleep instruction. It reads bit 7 of two standby-control bytes to make that choice. It halts the core, and it turns off the clock enables of the timer, the serial port and the DMA engine to match the chosen depth. It holds the core in that depth until an interrupt is pending or reset arrives. Then it brings the core back to running.

While the core sleeps at any depth, a timed event that is pending is still passed on for servicing. On the way into the deepest depth, the block gives the timer and the serial port a one-cycle catch-up strobe. That strobe falls in the last cycle their clocks still run, so they reach the current cycle before they freeze.

Top module: `lpm_ctl`

## Requirements
- R1: After reset, `state_o` is 0 (running), `core_halt` is 0, and all three clock enables are 1.
- R2: A sleep strobe accepted while `stby_a[7]` is 1 makes `state_o` equal 3 (standby) after the next rising edge, whatever `stby_b` holds.
- R3: A sleep strobe accepted while `stby_a[7]` is 0 and `stby_b[7]` is 1 makes `state_o` equal 2 (deep sleep) after the next edge.
- R4: A sleep strobe accepted while both bit 7s are 0 makes `state_o` equal 1 (sleep) after the next edge. Bits 6..0 of both bytes have no effect on the chosen depth.
- R5: In standby (3), `tmr_en`, `ser_en` and `dma_en` are all 0 and `core_halt` is 1. The enables fall on the same edge that loads the state.
- R6: `periph_sync` is 1 only in the cycle in which a sleep strobe heading for standby is accepted. In that cycle the timer and serial enables are still 1.
- R7: In deep sleep (2), `dma_en` is 0, `tmr_en` and `ser_en` are 1, and `core_halt` is 1.
- R8: In sleep (1), `core_halt` is 1 and all three enables are 1.
- R9: With `irq_pend` high in any sleep depth (1, 2 or 3), `state_o` is 0 after the next rising edge, and all enables are 1 and `core_halt` is 0.
- R10: A sleep strobe while `state_o` is not 0 has no effect on the state or the enables.
- R11: `evt_svc` follows `evt_pend` while `state_o` is not 0 and is 0 while running. `evt_pend` never changes the state.
- R12: Asserting `rst_n` low forces `state_o` to 0 at once, from any depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle strobe: a sleep instruction retired |
| stby_a | input | 8 | First standby-control byte; bit 7 selects standby |
| stby_b | input | 8 | Second standby-control byte; bit 7 selects deep sleep |
| irq_pend | input | 1 | An interrupt is pending |
| evt_pend | input | 1 | A timed event is pending |
| state_o | output | 2 | 0 running, 1 sleep, 2 deep sleep, 3 standby |
| core_halt | output | 1 | Core stopped |
| tmr_en | output | 1 | Timer clock enable |
| ser_en | output | 1 | Serial port clock enable |
| dma_en | output | 1 | DMA engine clock enable |
| periph_sync | output | 1 | Catch-up strobe to timer and serial before standby |
| evt_svc | output | 1 | Service the pending timed event while asleep |

## Verification
State, halt and the three enables are due one rising edge after a sleep strobe or a pending interrupt is sampled. Reset acts at once, with no edge. `periph_sync` and `evt_svc` are combinational and are due in the same cycle as their inputs. The bench drives inputs on the falling edge and compares every output 3 ns later, before the next rising edge. Its reference model updates its own state on that rising edge, so each compare sees exactly the edge's worth of change.

// File: rtl/lpm_ctl.sv
module lpm_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic [7:0] stby_a,
  input  logic [7:0] stby_b,
  input  logic       irq_pend,
  input  logic       evt_pend,
  output logic [1:0] state_o,
  output logic       core_halt,
  output logic       tmr_en,
  output logic       ser_en,
  output logic       dma_en,
  output logic       periph_sync,
  output logic       evt_svc
);
  localparam logic [1:0] RUN = 2'd0, SLP = 2'd1, DEEP = 2'd2, STBY = 2'd3;

  logic [1:0] st, nxt;
  logic       take;

  assign take = sleep_req && (st == RUN);

  always_comb begin
    nxt = st;
    if (take)
      nxt = stby_a[7] ? STBY : (stby_b[7] ? DEEP : SLP);
    else if (st != RUN && irq_pend)
      nxt = RUN;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= RUN;
    else        st <= nxt;

  assign state_o     = st;
  assign core_halt   = (st != RUN);
  assign tmr_en      = (st != STBY);
  assign ser_en      = (st != STBY);
  assign dma_en      = (st == RUN) || (st == SLP);
  assign periph_sync = take && stby_a[7];
  assign evt_svc     = evt_pend && (st != RUN);
endmodule

// File: rtl/lpm_ctl_chk.sv
module lpm_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       irq_pend,
  input logic [1:0] state_o,
  input logic       core_halt,
  input logic       tmr_en,
  input logic       ser_en,
  input logic       dma_en,
  input logic       periph_sync,
  input logic       evt_svc
);
  p_enter_standby_r6: assert property (@(posedge clk) disable iff (!rst_n)
    periph_sync |=> (state_o == 2'd3));
  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0 && irq_pend) |=> (state_o == 2'd0));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0 && !irq_pend) |=> $stable(state_o));
  p_dma_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> core_halt);
  p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_en == ser_en);
  p_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !core_halt |-> !evt_svc);
  p_sleep_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !core_halt) |=> core_halt);
endmodule

bind lpm_ctl lpm_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq_pend(irq_pend),
  .state_o(state_o), .core_halt(core_halt), .tmr_en(tmr_en), .ser_en(ser_en),
  .dma_en(dma_en), .periph_sync(periph_sync), .evt_svc(evt_svc)
);

// File: tb/sim_lpm_ctl.sv
module sim_lpm_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 1'b0, irq_pend = 1'b0, evt_pend = 1'b0;
  logic [7:0] stby_a = 8'h00, stby_b = 8'h00;
  logic [1:0] state_o;
  logic core_halt, tmr_en, ser_en, dma_en, periph_sync, evt_svc;
  int vecs = 0, bad = 0;
  int mst = 0;

  always #4 clk = ~clk;

  lpm_ctl u0 (.clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_a(stby_a),
    .stby_b(stby_b), .irq_pend(irq_pend), .evt_pend(evt_pend), .state_o(state_o),
    .core_halt(core_halt), .tmr_en(tmr_en), .ser_en(ser_en), .dma_en(dma_en),
    .periph_sync(periph_sync), .evt_svc(evt_svc));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) mst <= 0;
    else if (sleep_req && mst == 0) mst <= stby_a[7] ? 3 : (stby_b[7] ? 2 : 1);
    else if (mst != 0 && irq_pend) mst <= 0;

  task automatic cmp(string req, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    cmp(req, "state", state_o, mst);
    cmp(req, "halt", core_halt, mst != 0);
    cmp(req, "tmr_en", tmr_en, mst != 3);
    cmp(req, "ser_en", ser_en, mst != 3);
    cmp(req, "dma_en", dma_en, mst < 2);
    cmp(req, "sync", periph_sync, sleep_req && mst == 0 && stby_a[7]);
    cmp(req, "evt_svc", evt_svc, evt_pend && mst != 0);
  endtask

  task automatic step(string req, bit s, bit [7:0] a, bit [7:0] b, bit i, bit e);
    @(negedge clk);
    sleep_req = s; stby_a = a; stby_b = b; irq_pend = i; evt_pend = e;
    #3 check_all(req);
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #1 check_all("R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 8'h00, 8'h00, 0, 0);
    step("R6", 1, 8'h80, 8'hFF, 0, 0);
    step("R2", 0, 8'h00, 8'h00, 0, 0);
    step("R5", 0, 8'h00, 8'h00, 0, 1);
    step("R11", 0, 8'h00, 8'h00, 0, 1);
    step("R10", 1, 8'h00, 8'h80, 0, 0);
    step("R10", 0, 8'h00, 8'h00, 0, 0);
    step("R9", 0, 8'h00, 8'h00, 1, 0);
    step("R9", 0, 8'h00, 8'h00, 0, 0);
    step("R3", 1, 8'h7F, 8'h80, 0, 0);
    step("R7", 0, 8'h00, 8'h00, 0, 0);
    step("R10", 1, 8'h80, 8'h00, 0, 1);
    step("R9", 0, 8'h00, 8'h00, 1, 0);
    step("R11", 0, 8'h00, 8'h00, 0, 1);
    step("R4", 1, 8'h7F, 8'h7F, 0, 0);
    step("R8", 0, 8'h00, 8'h00, 0, 1);
    step("R9", 1, 8'h80, 8'h00, 1, 0);
    step("R9", 0, 8'h00, 8'h00, 0, 0);
    for (int k = 0; k < 40; k++)
      step("R4", (k % 3) == 0, 8'((k * 37) & 8'hC3), 8'((k * 53) ^ 8'h81),
           (k % 5) == 4, (k % 2) == 1);
    step("R2", 1, 8'h80, 8'h00, 0, 0);
    step("R5", 0, 8'h00, 8'h00, 0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check_all("R12");
    @(negedge clk);
    rst_n = 1'b1;
    step("R12", 0, 8'h00, 8'h00, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule